// File: doc/BRIEF.md
# CAN Transmit Buffer Request Scheduler

This block holds the control and status registers for a set of transmit message buffers that share one CAN transmitter. Software sets a send request and a two-bit priority in each buffer's register. The scheduler chooses the next pending buffer, hands its index to the protocol engine through a start/busy handshake, and folds the engine's tagged result pulses back into that buffer's status flags.

A request cleared by software while it is still set counts as an abort. The block reports it to the engine when that buffer is in flight. While a request is pending, writes to the buffer's message storage are refused. A mode input chooses between the basic register layout and the extended layout. The extended layout adds a completion flag in the top bit.

Top module: `can_tx_sched`

## Requirements
- R1: After reset every control register reads 0x00 and `txStart` is low.
- R2: Register layout: bit 3 = send request, bits 1:0 = priority, bit 6 = aborted, bit 5 = lost arbitration, bit 4 = bus error, bit 7 = completion. Bit 2 always reads 0. Bits 6:4 ignore software writes. With `mode` = 0, bit 7 reads 0.
- R3: Writing 1 to bit 3 while it is 0 sets the request and clears bits 6, 5 and 4.
- R4: Writing 0 to bit 3 while it is 1 clears the request and sets bit 6. If that buffer is the one handed to the engine, `txAbort` is high in the same cycle as the write, and `txIdx` holds that buffer's index.
- R5: The pending buffer with the highest priority value is chosen (3 highest, 0 lowest). On equal priority the higher index wins. A choice is made only while the scheduler is idle and `txBusy` is low.
- R6: `txStart` is a one-cycle pulse with `txIdx` giving the buffer index. The scheduler then waits for a result pulse whose `txResIdx` equals that index. Result pulses tagged with any other index change no register.
- R7: A `txDone` result clears bit 3. When `mode` is nonzero it also sets bit 7. When `mode` = 0, bit 7 is not set.
- R8: A `txLostArb` result sets bit 5 and a `txBusErr` result sets bit 4. Both leave bit 3 set, so the buffer is offered again.
- R9: Writing 0 to bit 7 clears it. Writing 1 to bit 7 does not set it.
- R10: `bufWrAccept` is high only when `bufWrEn` is high and the buffer selected by `bufWrSel` has bit 3 clear.
- R11: A `txAborted` result sets bit 6 and clears bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 = basic layout, nonzero = extended layout with completion flag |
| regWrEn | input | 1 | Control register write strobe |
| regWrSel | input | 2 | Buffer index for the register write |
| regWrData | input | 8 | Register write data |
| regRdSel | input | 2 | Buffer index for the register read |
| regRdData | output | 8 | Register read data (combinational) |
| bufWrEn | input | 1 | Write request to a buffer's message storage |
| bufWrSel | input | 2 | Buffer index for the storage write |
| bufWrAccept | output | 1 | Storage write is allowed |
| txStart | output | 1 | Start pulse to the protocol engine |
| txIdx | output | 2 | Buffer currently handed to the engine |
| txAbort | output | 1 | Abort request for the in-flight buffer |
| txBusy | input | 1 | Engine is occupied; no new choice is made |
| txDone | input | 1 | Result pulse: message sent |
| txLostArb | input | 1 | Result pulse: arbitration lost |
| txBusErr | input | 1 | Result pulse: bus error |
| txAborted | input | 1 | Result pulse: engine aborted the message |
| txResIdx | input | 2 | Buffer index tagging the result pulse |

## Verification
Selection is tried with requests and priorities on all three buffers:
- Every buffer at the same level, which shows that ties go to the higher index.
- A single buffer at a higher level than the rest, which shows that level wins over index.
- Pairs at equal and unequal levels, and a lone request.

The result path is driven with a lost-arbitration, bus-error, done sequence on one buffer. It also gets a done pulse tagged with the wrong index, which separates a retry from completion and checks that results are matched to the in-flight buffer. Aborts are tried with the buffer idle, with the buffer in flight, and as an engine-side report. This separates the flag update from the `txAbort` signal.

// File: rtl/can_tx_sched_pkg.sv
package can_tx_sched_pkg;
  localparam int REG_W  = 8;
  localparam int B_CIF  = 7;
  localparam int B_ABT  = 6;
  localparam int B_LARB = 5;
  localparam int B_ERR  = 4;
  localparam int B_REQ  = 3;
  localparam int B_RSV  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_OFFER, ST_ACTIVE} schedState_t;

  // filtered result strobes from control to datapath
  typedef struct packed {
    logic done;
    logic lostArb;
    logic busErr;
    logic aborted;
  } resStrobe_t;
endpackage

// File: rtl/can_tx_sched_ctrl.sv
module can_tx_sched_ctrl
  import can_tx_sched_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int IDX_W   = 2,
  parameter int PRIO_W  = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_BUF-1:0]             reqVec,
  input  logic [NUM_BUF-1:0][PRIO_W-1:0] prioVec,
  input  logic [NUM_BUF-1:0]             swAbortVec,
  input  logic                           txBusy,
  input  logic                           txDone,
  input  logic                           txLostArb,
  input  logic                           txBusErr,
  input  logic                           txAborted,
  input  logic [IDX_W-1:0]               txResIdx,
  output logic                           txStart,
  output logic [IDX_W-1:0]               txIdx,
  output logic                           txAbort,
  output resStrobe_t                     strobe,
  output logic [IDX_W-1:0]               strobeIdx
);
  schedState_t state;
  logic [IDX_W-1:0]  curIdx;
  logic              winValid;
  logic [IDX_W-1:0]  winIdx;
  logic [PRIO_W-1:0] winPrio;
  logic              resHit;
  logic              anyRes;

  // ascending scan with >= hands ties to the higher index
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPrio  = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (reqVec[i] && (!winValid || prioVec[i] >= winPrio)) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = prioVec[i];
      end
    end
  end

  assign resHit = (state == ST_ACTIVE) && (txResIdx == curIdx);
  assign anyRes = txDone | txLostArb | txBusErr | txAborted;

  always_comb begin
    strobe.done    = resHit & txDone;
    strobe.lostArb = resHit & txLostArb;
    strobe.busErr  = resHit & txBusErr;
    strobe.aborted = resHit & txAborted;
  end
  assign strobeIdx = curIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (winValid && !txBusy) begin
          curIdx <= winIdx;
          state  <= ST_OFFER;
        end
        ST_OFFER: state <= ST_ACTIVE;
        ST_ACTIVE: if (resHit && anyRes) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign txStart = (state == ST_OFFER);
  assign txIdx   = curIdx;
  assign txAbort = (state != ST_IDLE) && swAbortVec[curIdx];
endmodule

// File: rtl/can_tx_sched_dp.sv
module can_tx_sched_dp
  import can_tx_sched_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int IDX_W   = 2,
  parameter int PRIO_W  = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           extMode,
  input  logic                           regWrEn,
  input  logic [IDX_W-1:0]               regWrSel,
  input  logic [REG_W-1:0]               regWrData,
  input  logic [IDX_W-1:0]               regRdSel,
  output logic [REG_W-1:0]               regRdData,
  input  logic                           bufWrEn,
  input  logic [IDX_W-1:0]               bufWrSel,
  output logic                           bufWrAccept,
  input  resStrobe_t                     strobe,
  input  logic [IDX_W-1:0]               strobeIdx,
  output logic [NUM_BUF-1:0]             reqVec,
  output logic [NUM_BUF-1:0][PRIO_W-1:0] prioVec,
  output logic [NUM_BUF-1:0]             swAbortVec
);
  logic [NUM_BUF-1:0][REG_W-1:0] regQ;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] nxt;
    logic             hwSel;
    logic             swSel;

    assign hwSel = (strobeIdx == IDX_W'(i));
    assign swSel = regWrEn && (regWrSel == IDX_W'(i));
    assign swAbortVec[i] = swSel && !regWrData[B_REQ] && q[B_REQ];

    always_comb begin
      nxt = q;
      if (hwSel) begin
        if (strobe.done) begin
          nxt[B_REQ] = 1'b0;
          if (extMode) nxt[B_CIF] = 1'b1;
        end
        if (strobe.lostArb) nxt[B_LARB] = 1'b1;
        if (strobe.busErr)  nxt[B_ERR]  = 1'b1;
        if (strobe.aborted) begin
          nxt[B_REQ] = 1'b0;
          nxt[B_ABT] = 1'b1;
        end
      end
      if (swSel) begin
        nxt[PRIO_W-1:0] = regWrData[PRIO_W-1:0];
        if (!regWrData[B_CIF]) nxt[B_CIF] = 1'b0;
        if (regWrData[B_REQ] && !q[B_REQ]) begin
          nxt[B_REQ]  = 1'b1;
          nxt[B_ABT]  = 1'b0;
          nxt[B_LARB] = 1'b0;
          nxt[B_ERR]  = 1'b0;
        end else if (!regWrData[B_REQ] && q[B_REQ]) begin
          nxt[B_REQ] = 1'b0;
          nxt[B_ABT] = 1'b1;
        end
      end
      nxt[B_RSV] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else       q <= nxt;
    end

    assign regQ[i]    = q;
    assign reqVec[i]  = q[B_REQ];
    assign prioVec[i] = q[PRIO_W-1:0];
  end

  always_comb begin
    regRdData = '0;
    if (int'(regRdSel) < NUM_BUF) begin
      regRdData = regQ[regRdSel];
      regRdData[B_CIF] = regQ[regRdSel][B_CIF] & extMode;
    end
  end

  assign bufWrAccept = bufWrEn && (int'(bufWrSel) < NUM_BUF) && !reqVec[bufWrSel];
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import can_tx_sched_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int PRIO_W  = 2,
  parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regWrSel,
  input  logic [7:0]       regWrData,
  input  logic [IDX_W-1:0] regRdSel,
  output logic [7:0]       regRdData,
  input  logic             bufWrEn,
  input  logic [IDX_W-1:0] bufWrSel,
  output logic             bufWrAccept,
  output logic             txStart,
  output logic [IDX_W-1:0] txIdx,
  output logic             txAbort,
  input  logic             txBusy,
  input  logic             txDone,
  input  logic             txLostArb,
  input  logic             txBusErr,
  input  logic             txAborted,
  input  logic [IDX_W-1:0] txResIdx
);
  logic [NUM_BUF-1:0]             reqVec;
  logic [NUM_BUF-1:0][PRIO_W-1:0] prioVec;
  logic [NUM_BUF-1:0]             swAbortVec;
  resStrobe_t                     strobe;
  logic [IDX_W-1:0]               strobeIdx;

  can_tx_sched_ctrl #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioVec(prioVec),
    .swAbortVec(swAbortVec), .txBusy(txBusy), .txDone(txDone),
    .txLostArb(txLostArb), .txBusErr(txBusErr), .txAborted(txAborted),
    .txResIdx(txResIdx), .txStart(txStart), .txIdx(txIdx),
    .txAbort(txAbort), .strobe(strobe), .strobeIdx(strobeIdx)
  );

  can_tx_sched_dp #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .extMode(mode != 2'd0),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .regRdSel(regRdSel), .regRdData(regRdData),
    .bufWrEn(bufWrEn), .bufWrSel(bufWrSel), .bufWrAccept(bufWrAccept),
    .strobe(strobe), .strobeIdx(strobeIdx),
    .reqVec(reqVec), .prioVec(prioVec), .swAbortVec(swAbortVec)
  );
endmodule

// File: rtl/can_tx_sched_chk.sv
module can_tx_sched_chk #(
  parameter int NUM_BUF = 3,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         mode,
  input logic [7:0]         regRdData,
  input logic               bufWrEn,
  input logic               bufWrAccept,
  input logic               txStart,
  input logic               txBusy,
  input logic [NUM_BUF-1:0] reqVec
);
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  a_r5_start_needs_idle_engine: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(!txBusy));

  a_r5_start_has_pending: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> ($past(reqVec) != '0));

  a_r2_rsv_bit_zero: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[2]);

  a_r2_basic_top_bit_zero: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |-> !regRdData[7]);

  a_r10_accept_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    bufWrAccept |-> bufWrEn);
endmodule

bind can_tx_sched can_tx_sched_chk #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .regRdData(regRdData),
  .bufWrEn(bufWrEn), .bufWrAccept(bufWrAccept), .txStart(txStart),
  .txBusy(txBusy), .reqVec(reqVec)
);

// File: tb/tb_can_tx_sched.sv
`timescale 1ns/1ps
module tb_can_tx_sched;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       regWrEn = 1'b0;
  logic [1:0] regWrSel = '0;
  logic [7:0] regWrData = '0;
  logic [1:0] regRdSel = '0;
  logic [7:0] regRdData;
  logic       bufWrEn = 1'b0;
  logic [1:0] bufWrSel = '0;
  logic       bufWrAccept;
  logic       txStart;
  logic [1:0] txIdx;
  logic       txAbort;
  logic       txBusy = 1'b1;
  logic       txDone = 1'b0, txLostArb = 1'b0, txBusErr = 1'b0, txAborted = 1'b0;
  logic [1:0] txResIdx = '0;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  can_tx_sched dut (.*);

  // {req[2:0], prio2, prio1, prio0, expected index}
  localparam int NVEC = 8;
  localparam logic [10:0] VEC [NVEC] = '{
    {3'b111, 2'd0, 2'd0, 2'd0, 2'd2},
    {3'b111, 2'd0, 2'd0, 2'd3, 2'd0},
    {3'b011, 2'd0, 2'd1, 2'd1, 2'd1},
    {3'b101, 2'd2, 2'd0, 2'd2, 2'd2},
    {3'b001, 2'd0, 2'd0, 2'd0, 2'd0},
    {3'b110, 2'd1, 2'd3, 2'd0, 2'd1},
    {3'b111, 2'd2, 2'd2, 2'd1, 2'd2},
    {3'b011, 2'd0, 2'd1, 2'd2, 2'd0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    txBusy = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, output logic [7:0] data);
    regRdSel = sel;
    #1;
    data = regRdData;
  endtask

  task automatic waitStart(output logic [1:0] idx);
    bit seen = 0;
    idx = 2'd3;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(negedge clk);
      if (txStart) begin seen = 1; idx = txIdx; end
    end
  endtask

  // kind: 0 done, 1 lost arbitration, 2 bus error, 3 aborted
  task automatic engRes(input int kind, input logic [1:0] idx);
    @(negedge clk);
    txResIdx = idx;
    txDone = (kind == 0); txLostArb = (kind == 1);
    txBusErr = (kind == 2); txAborted = (kind == 3);
    @(negedge clk);
    {txDone, txLostArb, txBusErr, txAborted} = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [1:0] idx;

    // R1: reset state
    doReset();
    for (int b = 0; b < 3; b++) begin
      rdReg(2'(b), v);
      chk("R1 reset register", v, 8'h00);
    end
    chk("R1 no start after reset", {7'd0, txStart}, 8'h00);

    // R5 vector walk: priority order and tie break, R7 completion
    for (int n = 0; n < NVEC; n++) begin
      doReset();
      mode = 2'd1;
      for (int b = 0; b < 3; b++)
        wrReg(2'(b), {4'b0000, VEC[n][8+b], 1'b0, VEC[n][2+2*b +: 2]});
      repeat (3) @(negedge clk);
      chk("R5 no start while busy", {7'd0, txStart}, 8'h00);
      txBusy = 1'b0;
      waitStart(idx);
      chk($sformatf("R5 vector %0d winner", n), {6'd0, idx}, {6'd0, VEC[n][1:0]});
      engRes(0, idx);
      rdReg(idx, v);
      chk($sformatf("R7 vector %0d after done", n), v,
          {8'h80 | {6'd0, VEC[n][2+2*idx +: 2]}});
    end

    // R2, R3, R4, R10: basic layout, idle abort, storage lock
    doReset();
    mode = 2'd0;
    wrReg(2'd0, 8'hFF);
    rdReg(2'd0, v);
    chk("R2 writable bits only", v, 8'h0B);
    @(negedge clk);
    bufWrEn = 1'b1; bufWrSel = 2'd0; #1;
    chk("R10 locked storage write", {7'd0, bufWrAccept}, 8'h00);
    bufWrSel = 2'd1; #1;
    chk("R10 free storage write", {7'd0, bufWrAccept}, 8'h01);
    bufWrEn = 1'b0;
    wrReg(2'd0, 8'h03);
    rdReg(2'd0, v);
    chk("R4 idle abort", v, 8'h43);
    wrReg(2'd0, 8'h0A);
    rdReg(2'd0, v);
    chk("R3 new request clears aborted", v, 8'h0A);

    // R8, R6, R7, R9, R3: retry path on buffer 1
    doReset();
    mode = 2'd1;
    wrReg(2'd1, 8'h09);
    txBusy = 1'b0;
    waitStart(idx);
    chk("R5 single request start", {6'd0, idx}, 8'h01);
    engRes(1, 2'd1);
    rdReg(2'd1, v);
    chk("R8 lost arbitration flag", v, 8'h29);
    waitStart(idx);
    chk("R8 retry after lost arbitration", {6'd0, idx}, 8'h01);
    engRes(0, 2'd0);
    rdReg(2'd1, v);
    chk("R6 foreign done ignored", v, 8'h29);
    engRes(2, 2'd1);
    rdReg(2'd1, v);
    chk("R8 bus error flag", v, 8'h39);
    waitStart(idx);
    chk("R8 retry after bus error", {6'd0, idx}, 8'h01);
    engRes(0, 2'd1);
    rdReg(2'd1, v);
    chk("R7 done sets completion", v, 8'hB1);
    wrReg(2'd1, 8'h81);
    rdReg(2'd1, v);
    chk("R9 writing one keeps completion", v, 8'hB1);
    wrReg(2'd1, 8'h01);
    rdReg(2'd1, v);
    chk("R9 writing zero clears completion", v, 8'h31);
    txBusy = 1'b1;
    wrReg(2'd1, 8'h09);
    rdReg(2'd1, v);
    chk("R3 request clears error flags", v, 8'h09);

    // R11: engine-side abort
    doReset();
    mode = 2'd1;
    wrReg(2'd0, 8'h08);
    txBusy = 1'b0;
    waitStart(idx);
    engRes(3, 2'd0);
    rdReg(2'd0, v);
    chk("R11 engine abort", v, 8'h40);

    // R4: abort of the in-flight buffer
    doReset();
    mode = 2'd1;
    wrReg(2'd2, 8'h0A);
    txBusy = 1'b0;
    waitStart(idx);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 2'd2; regWrData = 8'h02; #1;
    chk("R4 abort signal to engine", {5'd0, txAbort, txIdx}, 8'h06);
    @(negedge clk);
    regWrEn = 1'b0;
    rdReg(2'd2, v);
    chk("R4 in-flight abort flag", v, 8'h42);
    engRes(3, 2'd2);
    begin
      bit again = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (txStart) again = 1;
      end
      chk("R4 no restart after abort", {7'd0, again}, 8'h00);
    end

    // R7: basic layout leaves completion clear
    doReset();
    mode = 2'd0;
    wrReg(2'd0, 8'h08);
    txBusy = 1'b0;
    waitStart(idx);
    engRes(0, 2'd0);
    rdReg(2'd0, v);
    chk("R7 basic layout done", v, 8'h00);
    mode = 2'd1;
    rdReg(2'd0, v);
    chk("R7 basic layout never set completion", v, 8'h00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule